// File: doc/BRIEF.md
# NAND / PC Card Bus Access Sequencer

This block turns a single internal request into one timed access on an external NAND flash or PC Card style bus. A request carries an address, a read/write flag and write data. Once accepted, the block walks through a fixed order of phases: address setup, command strobe, address/data hold and then a one-cycle chip-enable gap. Each of these phases is measured in system clock cycles. On writes a separate turnaround delay keeps the data pins undriven for a programmed number of cycles, counted from the first setup cycle.

The four timing fields are 8-bit inputs. The setup and strobe fields encode their length as value plus one. The hold field encodes its length directly, and a value of zero is treated as one. The block takes a copy of all four fields when it accepts a request, so the fields can change freely while an access is in flight. For NAND devices, a write to an address with bit 16 set asserts the command-latch output, and a write to an address with bit 17 set asserts the address-latch output. Software sends commands and addresses by writing to those locations.

Completion is signalled by a one-cycle done pulse. Read data is valid in the same cycle. The data bus is split into an output value, an output enable and an input value, and a tri-state pad outside the block joins them.

Top module: `nand_bus_seq`

## Requirements
- R1: While reset is held, and after it is released, chip enable, write enable and output enable are high (inactive), the data output enable is low, done is low and req_ready is high.
- R2: After a request is accepted, chip enable is low and both strobes are high, with the request address on bus_addr, for setup field + 1 cycles. This covers 1 to 256 cycles. The address stays stable for as long as chip enable is low.
- R3: After setup, the strobe is held low for wait field + 1 cycles. The strobe is write enable on a write and output enable on a read. The other strobe stays high, and the two strobes are never low together.
- R4: After the strobe is released, chip enable stays low with the address valid for hold field cycles, where a value of 0 counts as 1. On writes, the write data is still driven throughout this phase.
- R5: On a write, bus_dq_oe stays low for the first min(hiz field, access length) cycles of the access, counted from the first setup cycle. After that it stays high, with bus_dq_out equal to the write data, until hold ends. On a read, bus_dq_oe is never high.
- R6: On a read, rdata holds the value that was on bus_dq_in during the last cycle of the strobe phase.
- R7: done is high for exactly one cycle, the cycle right after the last hold cycle. Chip enable is high in that cycle. req_ready is low from acceptance until that cycle has passed.
- R8: nand_cle is high during every chip-enable-low cycle of a write whose address has bit 16 set. nand_ale is high during every chip-enable-low cycle of a write whose address has bit 17 set. Both are low for reads and for other addresses.
- R9: Changing the timing fields after a request has been accepted does not change any phase length of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | 8 | Setup length minus one |
| cfg_wait | input | 8 | Strobe length minus one |
| cfg_hold | input | 8 | Hold length (0 treated as 1) |
| cfg_hiz | input | 8 | Write data turnaround cycles |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_addr | output | ADDR_W | External address |
| nand_cle | output | 1 | NAND command latch |
| nand_ale | output | 1 | NAND address latch |
| bus_dq_out | output | DATA_W | Data to drive |
| bus_dq_oe | output | 1 | Data pad output enable |
| bus_dq_in | input | DATA_W | Data from pad |

## Verification
A table of accesses exercises the timing fields at their minimum codes, at mid values and at long values. It covers both directions and addresses with bit 16, bit 17, both bits or neither bit set. These cases separate the plus-one encoding of setup and strobe from the direct encoding of hold, and they show that the latch outputs depend on the direction as well as on the address. The bench drives the correct read value on the data input only during the final strobe cycle, which shows whether the capture happens on exactly that edge. Directed cases cover the 256-cycle maximum, a turnaround longer than the setup phase, timing fields rewritten in mid-access, and requests issued back to back.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 8,
  parameter int CLE_BIT = 16,
  parameter int ALE_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [7:0]        cfg_setup,
  input  logic [7:0]        cfg_wait,
  input  logic [7:0]        cfg_hold,
  input  logic [7:0]        cfg_hiz,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_ce_n,
  output logic              bus_we_n,
  output logic              bus_oe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DATA_W-1:0] bus_dq_out,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_in
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WAIT, S_HOLD, S_GAP} st_t;

  st_t               st;
  logic [7:0]        cnt, hz, wait_q, hold_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  wire active = (st == S_SETUP) || (st == S_WAIT) || (st == S_HOLD);
  wire last   = (cnt == 8'd0);

  assign req_ready  = (st == S_IDLE);
  assign bus_ce_n   = !active;
  assign bus_we_n   = !((st == S_WAIT) && wr_q);
  assign bus_oe_n   = !((st == S_WAIT) && !wr_q);
  assign bus_addr   = addr_q;
  assign bus_dq_out = wdata_q;
  assign bus_dq_oe  = active && wr_q && (hz == 8'd0);
  assign nand_cle   = active && wr_q && addr_q[CLE_BIT];
  assign nand_ale   = active && wr_q && addr_q[ALE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      hz      <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active && hz != 8'd0) hz <= hz - 8'd1;
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_SETUP;
          cnt     <= cfg_setup;
          hz      <= cfg_hiz;
          wait_q  <= cfg_wait;
          hold_q  <= (cfg_hold == 8'd0) ? 8'd0 : cfg_hold - 8'd1;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        S_SETUP: if (last) begin
          st  <= S_WAIT;
          cnt <= wait_q;
        end else cnt <= cnt - 8'd1;
        S_WAIT: if (last) begin
          st  <= S_HOLD;
          cnt <= hold_q;
          if (!wr_q) rdata <= bus_dq_in;
        end else cnt <= cnt - 8'd1;
        S_HOLD: if (last) begin
          st   <= S_GAP;
          done <= 1'b1;
        end else cnt <= cnt - 8'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n));
  p_strobe_in_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_oe_n) |-> !bus_ce_n);
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_addr));
  p_done_ce_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_ce_n);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dq_oe |-> (!bus_ce_n && bus_oe_n));
  p_latch_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> (!bus_ce_n && bus_oe_n));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce_n |-> !req_ready);

endmodule

// File: tb/tb_nand_bus_seq.sv
`timescale 1ns/1ps
module tb_nand_bus_seq;
  localparam int AW = 26;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [7:0] cfg_setup = 0, cfg_wait = 0, cfg_hold = 0, cfg_hiz = 0;
  logic done, bus_ce_n, bus_we_n, bus_oe_n, nand_cle, nand_ale, bus_dq_oe;
  logic [DW-1:0] rdata, bus_dq_out, bus_dq_in;
  logic [AW-1:0] bus_addr;

  int checks = 0, fails = 0;
  logic [DW-1:0] rd_drive = '0;
  logic [8:0] rd_idx = '0, oe_cyc;

  always #2 clk = ~clk;

  always_ff @(posedge clk) oe_cyc <= bus_oe_n ? 9'd0 : oe_cyc + 9'd1;
  assign bus_dq_in = (!bus_oe_n && oe_cyc == rd_idx) ? rd_drive : 8'hEE;

  nand_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
    .done(done), .rdata(rdata), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in));

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [7:0]    s, w, h, z;
    logic [DW-1:0] rd;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 26'h0010000, 8'h90, 8'd0, 8'd0, 8'd0,   8'd0, 8'h00},
    '{1'b1, 26'h0020000, 8'h3C, 8'd2, 8'd3, 8'd1,   8'd2, 8'h00},
    '{1'b0, 26'h0000ABC, 8'h00, 8'd1, 8'd4, 8'd2,   8'd0, 8'hC3},
    '{1'b1, 26'h0001234, 8'h5A, 8'd5, 8'd1, 8'd4,   8'd7, 8'h00},
    '{1'b0, 26'h0030000, 8'h00, 8'd0, 8'd0, 8'd3,   8'd0, 8'h7E},
    '{1'b1, 26'h3FFFFFF, 8'hFF, 8'd3, 8'd7, 8'd255, 8'd0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input vec_t v, input bit mutate);
    int ns = 0, nw = 0, nh = 0, nz = 0, guard = 0;
    int bad_addr = 0, bad_data = 0, bad_cle = 0, bad_ale = 0, bad_other = 0, bad_drv = 0;
    int exp_h, exp_z, total;
    bit strobed = 0, driven = 0;
    exp_h = (v.h == 0) ? 1 : int'(v.h);
    total = int'(v.s) + 1 + int'(v.w) + 1 + exp_h;
    exp_z = v.wr ? ((int'(v.z) < total) ? int'(v.z) : total) : 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_setup = v.s; cfg_wait = v.w; cfg_hold = v.h; cfg_hiz = v.z;
    rd_drive = v.rd; rd_idx = {1'b0, v.w};
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (mutate) begin
      cfg_setup = 8'd40; cfg_wait = 8'd40; cfg_hold = 8'd40; cfg_hiz = 8'd40;
    end
    chk(!req_ready, "R7 ready low in access", req_ready, 0);
    while (!done && guard < 2000) begin
      guard++;
      if (!bus_ce_n) begin
        if ((v.wr && !bus_we_n) || (!v.wr && !bus_oe_n)) begin nw++; strobed = 1; end
        else if (!strobed) ns++;
        else nh++;
        if ((v.wr && !bus_oe_n) || (!v.wr && !bus_we_n)) bad_other++;
        if (bus_addr != v.addr) bad_addr++;
        if (nand_cle != (v.wr && v.addr[16])) bad_cle++;
        if (nand_ale != (v.wr && v.addr[17])) bad_ale++;
        if (!v.wr && bus_dq_oe) bad_drv++;
        if (v.wr && !bus_dq_oe && driven) bad_drv++;
        if (v.wr && !bus_dq_oe && !driven) nz++;
        if (bus_dq_oe) begin driven = 1; if (bus_dq_out != v.wd) bad_data++; end
      end
      @(negedge clk);
    end
    chk(done, "R7 done reached", done, 1);
    chk(bus_ce_n, "R7 ce high in done cycle", bus_ce_n, 1);
    chk(ns == int'(v.s) + 1, mutate ? "R9 setup length" : "R2 setup length", ns, int'(v.s) + 1);
    chk(nw == int'(v.w) + 1, mutate ? "R9 strobe length" : "R3 strobe length", nw, int'(v.w) + 1);
    chk(nh == exp_h, mutate ? "R9 hold length" : "R4 hold length", nh, exp_h);
    chk(bad_other == 0, "R3 other strobe high", bad_other, 0);
    chk(bad_addr == 0, "R2 address valid", bad_addr, 0);
    chk(bad_cle == 0, "R8 cle", bad_cle, 0);
    chk(bad_ale == 0, "R8 ale", bad_ale, 0);
    chk(bad_drv == 0, "R5 drive window", bad_drv, 0);
    if (v.wr) begin
      chk(nz == exp_z, "R5 turnaround cycles", nz, exp_z);
      chk(bad_data == 0, "R4 write data held", bad_data, 0);
    end else
      chk(rdata == v.rd, "R6 read capture", rdata, v.rd);
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk(bus_ce_n && bus_we_n && bus_oe_n && !bus_dq_oe && !done, "R1 outputs in reset",
        {bus_ce_n, bus_we_n, bus_oe_n, bus_dq_oe, done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && bus_ce_n && !bus_dq_oe, "R1 idle after reset",
        {req_ready, bus_ce_n, bus_dq_oe}, 3'b110);

    for (int i = 0; i < 6; i++) access(VEC[i], 1'b0);

    d = '{1'b0, 26'h0000055, 8'h00, 8'd255, 8'd255, 8'd1, 8'd0, 8'hA6};
    access(d, 1'b0);
    d = '{1'b1, 26'h0000077, 8'h81, 8'd0, 8'd0, 8'd2, 8'd200, 8'h00};
    access(d, 1'b0);
    d = '{1'b1, 26'h0010001, 8'h12, 8'd2, 8'd1, 8'd3, 8'd1, 8'h00};
    access(d, 1'b1);
    d = '{1'b0, 26'h0000100, 8'h00, 8'd0, 8'd2, 8'd0, 8'd0, 8'h39};
    access(d, 1'b1);
    access(d, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule